// File: doc/BRIEF.md
# Dual-Loop Hysteretic Lock Detector with Status Select

This block watches two phase-locked loops, an IF loop and an RF loop, and raises one lock flag for each. For each loop it receives the single-cycle edge pulses that the phase detector's reference side and feedback side produce, already synchronous to a fast measurement clock. Once per reference cycle it measures how many clock ticks separate the two edges, whichever edge comes first, and passes the result to a hysteretic filter. The filter declares lock only after a run of tight measurements. Once locked, it tolerates a window twice as wide, and it drops lock on the first measurement outside that window.

A 3-bit select steers one of eight sources onto a single status pin. The sources are an externally generated analog lock indication, either digital lock flag, the AND of both flags, or one of the four divider outputs. A power-down input per loop forces that loop's flag low and discards its progress toward lock.

Top module: `lock_status_unit`

## Requirements
- R1: A measurement's error is the number of clock cycles from the first edge of a pair to its partner (0 when both arrive in the same cycle). While unlocked, a measurement counts as good only if its error is strictly less than ENTRY_TICKS (default 8). An error of exactly ENTRY_TICKS is bad.
- R2: An unlocked loop becomes locked after LOCK_COUNT (default 5) consecutive good measurements, and not after fewer.
- R3: While unlocked, any bad measurement resets the run of good measurements to zero.
- R4: While locked, a measurement with error up to and including EXIT_TICKS = 2*ENTRY_TICKS (default 16) keeps the loop locked.
- R5: While locked, a single measurement with error above EXIT_TICKS clears the lock flag.
- R6: A missing partner edge is a bad measurement. This covers a second reference edge arriving before the feedback edge, a second feedback edge arriving before the reference edge, and WAIT_LIMIT (default 255) cycles passing without a partner.
- R7: A pair in which the feedback edge leads is measured in the same way as one in which the reference edge leads.
- R8: While a loop's power-down input is high, its lock flag is low in the same cycle. The power-down also clears the run count, so LOCK_COUNT new good measurements are needed after release.
- R9: The two loops are independent. Pulses and power-down on one loop do not change the other loop's flag.
- R10: The status output follows the select value: 0 analog lock input, 1 IF lock flag, 2 RF lock flag, 3 IF flag AND RF flag, 4 IF reference divider, 5 IF feedback divider, 6 RF reference divider, 7 RF feedback divider. Bit 0 of each per-loop vector is IF and bit 1 is RF.
- R11: After reset both lock flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 2 | Reference-edge pulse per loop (bit 0 IF, bit 1 RF) |
| fb_pulse | input | 2 | Feedback-edge pulse per loop |
| pwr_dn | input | 2 | Power-down per loop |
| ana_lock | input | 1 | Analog lock indication, routed on select 0 |
| ref_div | input | 2 | Reference divider output per loop |
| fb_div | input | 2 | Feedback divider output per loop |
| stat_sel | input | 3 | Status source select |
| lock_flag | output | 2 | Digital lock flag per loop |
| stat_out | output | 1 | Selected status signal |

## Verification
The checker runs on every cycle. It checks that a flag is low whenever its loop is powered down. It checks that a flag changes only in the cycle after a finished measurement. It checks that a rising flag always follows a measurement below the entry threshold. It checks that a locked loop loses its flag after a measurement beyond the exit threshold, and that the combined select presents the AND of both flags. The bench scenarios are needed for the history-dependent behaviour: the exact count of five, the reset of the run by a single bad cycle, the boundary values at both thresholds, the reverse edge order, and the two kinds of missing partner. They also cover relock after power-down and the independence of the two loops.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam int NUM_LOOPS = 2;
  localparam int LOOP_IF   = 0;
  localparam int LOOP_RF   = 1;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } meas_state_e;

  typedef enum logic [2:0] {
    SEL_ANALOG  = 3'd0,
    SEL_IF_LOCK = 3'd1,
    SEL_RF_LOCK = 3'd2,
    SEL_BOTH    = 3'd3,
    SEL_IF_REF  = 3'd4,
    SEL_IF_FB   = 3'd5,
    SEL_RF_REF  = 3'd6,
    SEL_RF_FB   = 3'd7
  } stat_sel_e;

endpackage

// File: rtl/phase_gap_meter.sv
module phase_gap_meter
  import lockdet_pkg::*;
#(
  parameter int WAIT_LIMIT = 255,
  parameter int CNT_W      = $clog2(WAIT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_err,
  output logic             meas_miss
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(WAIT_LIMIT);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  meas_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic             miss_q, miss_d;
  logic             lead_edge, lag_edge;

  // In a wait state: lead_edge repeats the edge that opened the window,
  // lag_edge is the partner that closes it.
  always_comb begin
    lead_edge = 1'b0;
    lag_edge  = 1'b0;
    if (state_q == MS_WAIT_FB) begin
      lead_edge = ref_pulse;
      lag_edge  = fb_pulse;
    end else if (state_q == MS_WAIT_REF) begin
      lead_edge = fb_pulse;
      lag_edge  = ref_pulse;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    valid_d = 1'b0;
    err_d   = err_q;
    miss_d  = miss_q;
    if (pwr_dn) begin
      state_d = MS_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        MS_IDLE: begin
          if (ref_pulse && fb_pulse) begin
            valid_d = 1'b1;
            err_d   = '0;
            miss_d  = 1'b0;
          end else if (ref_pulse) begin
            state_d = MS_WAIT_FB;
            cnt_d   = ONE_V;
          end else if (fb_pulse) begin
            state_d = MS_WAIT_REF;
            cnt_d   = ONE_V;
          end
        end
        MS_WAIT_FB, MS_WAIT_REF: begin
          if (lag_edge) begin
            valid_d = 1'b1;
            err_d   = cnt_q;
            miss_d  = 1'b0;
            if (lead_edge) begin
              cnt_d = ONE_V;
            end else begin
              state_d = MS_IDLE;
              cnt_d   = '0;
            end
          end else if (lead_edge) begin
            valid_d = 1'b1;
            err_d   = cnt_q;
            miss_d  = 1'b1;
            cnt_d   = ONE_V;
          end else if (cnt_q == LIMIT_V) begin
            valid_d = 1'b1;
            err_d   = cnt_q;
            miss_d  = 1'b1;
            state_d = MS_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE_V;
          end
        end
        default: begin
          state_d = MS_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      miss_q  <= miss_d;
    end
  end

  assign meas_valid = valid_q;
  assign meas_err   = err_q;
  assign meas_miss  = miss_q;

endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis #(
  parameter int CNT_W       = 8,
  parameter int ENTRY_TICKS = 8,
  parameter int EXIT_TICKS  = 16,
  parameter int LOCK_COUNT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_err,
  input  logic             meas_miss,
  output logic             lock_o
);

  localparam int GC_W = $clog2(LOCK_COUNT + 1);
  localparam logic [GC_W-1:0]  LAST_GOOD = GC_W'(LOCK_COUNT - 1);
  localparam logic [CNT_W:0]   ENTRY_V   = (CNT_W + 1)'(ENTRY_TICKS);
  localparam logic [CNT_W:0]   EXIT_V    = (CNT_W + 1)'(EXIT_TICKS);

  logic            locked_q, locked_d;
  logic [GC_W-1:0] good_q, good_d;
  logic            tight_ok, wide_ok;
  logic            upd_en;

  // Compare in one extra bit so a threshold at the top of the counter range stays valid.
  assign tight_ok = !meas_miss && ({1'b0, meas_err} < ENTRY_V);
  assign wide_ok  = !meas_miss && ({1'b0, meas_err} <= EXIT_V);
  assign upd_en   = pwr_dn || meas_valid;

  always_comb begin
    locked_d = locked_q;
    good_d   = good_q;
    if (pwr_dn) begin
      locked_d = 1'b0;
      good_d   = '0;
    end else if (meas_valid) begin
      if (locked_q) begin
        if (!wide_ok) begin
          locked_d = 1'b0;
          good_d   = '0;
        end
      end else if (tight_ok) begin
        if (good_q == LAST_GOOD) begin
          locked_d = 1'b1;
          good_d   = '0;
        end else begin
          good_d = good_q + GC_W'(1);
        end
      end else begin
        good_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      good_q   <= '0;
    end else if (upd_en) begin
      locked_q <= locked_d;
      good_q   <= good_d;
    end
  end

  assign lock_o = locked_q && !pwr_dn;

endmodule

// File: rtl/status_select.sv
module status_select
  import lockdet_pkg::*;
(
  input  logic                 ana_lock,
  input  logic [NUM_LOOPS-1:0] lock_flag,
  input  logic [NUM_LOOPS-1:0] ref_div,
  input  logic [NUM_LOOPS-1:0] fb_div,
  input  logic [2:0]           stat_sel,
  output logic                 stat_out
);

  always_comb begin
    unique case (stat_sel_e'(stat_sel))
      SEL_ANALOG:  stat_out = ana_lock;
      SEL_IF_LOCK: stat_out = lock_flag[LOOP_IF];
      SEL_RF_LOCK: stat_out = lock_flag[LOOP_RF];
      SEL_BOTH:    stat_out = lock_flag[LOOP_IF] && lock_flag[LOOP_RF];
      SEL_IF_REF:  stat_out = ref_div[LOOP_IF];
      SEL_IF_FB:   stat_out = fb_div[LOOP_IF];
      SEL_RF_REF:  stat_out = ref_div[LOOP_RF];
      SEL_RF_FB:   stat_out = fb_div[LOOP_RF];
      default:     stat_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/lock_status_unit.sv
module lock_status_unit
  import lockdet_pkg::*;
#(
  parameter int ENTRY_TICKS = 8,
  parameter int LOCK_COUNT  = 5,
  parameter int WAIT_LIMIT  = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pulse,
  input  logic [1:0] fb_pulse,
  input  logic [1:0] pwr_dn,
  input  logic       ana_lock,
  input  logic [1:0] ref_div,
  input  logic [1:0] fb_div,
  input  logic [2:0] stat_sel,
  output logic [1:0] lock_flag,
  output logic       stat_out
);

  localparam int EXIT_TICKS = 2 * ENTRY_TICKS;
  localparam int MAX_TICKS  = (WAIT_LIMIT > EXIT_TICKS) ? WAIT_LIMIT : EXIT_TICKS;
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);

  logic [NUM_LOOPS-1:0]            meas_valid_v;
  logic [NUM_LOOPS-1:0][CNT_W-1:0] meas_err_v;
  logic [NUM_LOOPS-1:0]            meas_miss_v;
  logic [NUM_LOOPS-1:0]            lock_v;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    phase_gap_meter #(
      .WAIT_LIMIT (WAIT_LIMIT),
      .CNT_W      (CNT_W)
    ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_dn     (pwr_dn[g]),
      .ref_pulse  (ref_pulse[g]),
      .fb_pulse   (fb_pulse[g]),
      .meas_valid (meas_valid_v[g]),
      .meas_err   (meas_err_v[g]),
      .meas_miss  (meas_miss_v[g])
    );

    lock_hysteresis #(
      .CNT_W       (CNT_W),
      .ENTRY_TICKS (ENTRY_TICKS),
      .EXIT_TICKS  (EXIT_TICKS),
      .LOCK_COUNT  (LOCK_COUNT)
    ) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_dn     (pwr_dn[g]),
      .meas_valid (meas_valid_v[g]),
      .meas_err   (meas_err_v[g]),
      .meas_miss  (meas_miss_v[g]),
      .lock_o     (lock_v[g])
    );
  end

  status_select u_sel (
    .ana_lock  (ana_lock),
    .lock_flag (lock_v),
    .ref_div   (ref_div),
    .fb_div    (fb_div),
    .stat_sel  (stat_sel),
    .stat_out  (stat_out)
  );

  assign lock_flag = lock_v;

endmodule

// File: rtl/lock_status_chk.sv
module lock_status_chk #(
  parameter int CNT_W       = 8,
  parameter int ENTRY_TICKS = 8,
  parameter int EXIT_TICKS  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            pwr_dn,
  input logic [1:0]            lock_flag,
  input logic [2:0]            stat_sel,
  input logic                  stat_out,
  input logic [1:0]            meas_valid_v,
  input logic [1:0][CNT_W-1:0] meas_err_v,
  input logic [1:0]            meas_miss_v
);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R8: power-down holds the flag low
    a_r8_pd_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn[g] |-> !lock_flag[g]);

    // R2: the flag rises only in the cycle after a finished measurement
    a_r2_rise_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_flag[g] && !meas_valid_v[g]) |=> !lock_flag[g]);

    // R1: a rising flag follows a measurement under the entry threshold
    a_r1_rise_needs_tight: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_flag[g]) |->
        ($past(!meas_miss_v[g]) && ($past(meas_err_v[g]) < CNT_W'(ENTRY_TICKS))));

    // R5: a measurement beyond the exit threshold drops lock
    a_r5_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_flag[g] && meas_valid_v[g] &&
       (meas_miss_v[g] || (meas_err_v[g] > CNT_W'(EXIT_TICKS)))) |=> !lock_flag[g]);

    // R4: without a measurement, a lock survives unless powered down
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_flag[g] && !meas_valid_v[g]) |=> (lock_flag[g] || pwr_dn[g]));
  end

  // R10: the combined select shows both flags ANDed
  a_r10_both_select: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel == 3'd3) |-> (stat_out == (lock_flag[0] && lock_flag[1])));

endmodule

bind lock_status_unit lock_status_chk #(
  .CNT_W       (CNT_W),
  .ENTRY_TICKS (ENTRY_TICKS),
  .EXIT_TICKS  (EXIT_TICKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_dn       (pwr_dn),
  .lock_flag    (lock_flag),
  .stat_sel     (stat_sel),
  .stat_out     (stat_out),
  .meas_valid_v (meas_valid_v),
  .meas_err_v   (meas_err_v),
  .meas_miss_v  (meas_miss_v)
);

// File: tb/lock_status_unit_test.sv
module lock_status_unit_test;

  localparam int ENTRY  = 8;
  localparam int EXITT  = 16;
  localparam int PERIOD = 32;

  logic       clk;
  logic       rst_n;
  logic [1:0] ref_pulse, fb_pulse, pwr_dn, ref_div, fb_div, lock_flag;
  logic       ana_lock, stat_out;
  logic [2:0] stat_sel;

  int n_checks = 0;
  int n_bad    = 0;

  lock_status_unit #(.ENTRY_TICKS(ENTRY), .LOCK_COUNT(5), .WAIT_LIMIT(255)) uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pwr_dn(pwr_dn), .ana_lock(ana_lock), .ref_div(ref_div), .fb_div(fb_div),
    .stat_sel(stat_sel), .lock_flag(lock_flag), .stat_out(stat_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One reference period: leading edge at cycle 0, partner at cycle gap.
  task automatic pair(input int lp, input bit fb_first, input int gap);
    for (int c = 0; c < PERIOD; c++) begin
      @(negedge clk);
      ref_pulse[lp] = fb_first ? (c == gap) : (c == 0);
      fb_pulse[lp]  = fb_first ? (c == 0)   : (c == gap);
    end
    @(negedge clk);
    ref_pulse[lp] = 1'b0;
    fb_pulse[lp]  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pairs(input int lp, input int n, input int gap);
    for (int k = 0; k < n; k++) pair(lp, k[0], gap);
  endtask

  task automatic pd_pulse(input int lp);
    @(negedge clk); pwr_dn[lp] = 1'b1;
    repeat (3) @(negedge clk); pwr_dn[lp] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R11 IF flag after reset", lock_flag[0], 1'b0);
    chk("R11 RF flag after reset", lock_flag[1], 1'b0);
  endtask

  task automatic t_entry_count;
    pd_pulse(0);
    for (int k = 0; k < 4; k++) pair(0, 1'b0, 3);
    chk("R2 four good cycles not enough", lock_flag[0], 1'b0);
    pair(0, 1'b0, 3);
    chk("R2 locked after five good cycles", lock_flag[0], 1'b1);
    pd_pulse(0);
    for (int k = 0; k < 5; k++) pair(0, 1'b1, 4);
    chk("R7 feedback-first pairs lock", lock_flag[0], 1'b1);
    pd_pulse(0);
    pairs(0, 5, 0);
    chk("R1 zero-error pairs lock", lock_flag[0], 1'b1);
  endtask

  task automatic t_entry_bound;
    pd_pulse(0);
    pairs(0, 6, ENTRY);
    chk("R1 error equal to entry threshold is bad", lock_flag[0], 1'b0);
    pairs(0, 5, ENTRY - 1);
    chk("R1 error just under entry threshold locks", lock_flag[0], 1'b1);
  endtask

  task automatic t_run_reset;
    pd_pulse(0);
    pairs(0, 4, 2);
    pair(0, 1'b0, 12);
    pairs(0, 4, 2);
    chk("R3 bad cycle restarts the run", lock_flag[0], 1'b0);
    pair(0, 1'b0, 2);
    chk("R3 fifth good after restart locks", lock_flag[0], 1'b1);
  endtask

  task automatic t_hold_drop;
    pd_pulse(0);
    pairs(0, 5, 1);
    pair(0, 1'b0, EXITT);
    chk("R4 error equal to exit threshold keeps lock", lock_flag[0], 1'b1);
    pair(0, 1'b1, 12);
    chk("R4 error between thresholds keeps lock", lock_flag[0], 1'b1);
    pair(0, 1'b0, EXITT + 1);
    chk("R5 error beyond exit threshold drops lock", lock_flag[0], 1'b0);
  endtask

  task automatic t_missing;
    pd_pulse(0);
    pairs(0, 5, 1);
    chk("R6 locked before missing edge", lock_flag[0], 1'b1);
    @(negedge clk); ref_pulse[0] = 1'b1;
    @(negedge clk); ref_pulse[0] = 1'b0;
    repeat (20) @(negedge clk);
    ref_pulse[0] = 1'b1;
    @(negedge clk); ref_pulse[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 second reference edge without feedback drops lock", lock_flag[0], 1'b0);
    pd_pulse(0);
    pairs(0, 5, 1);
    @(negedge clk); fb_pulse[0] = 1'b1;
    @(negedge clk); fb_pulse[0] = 1'b0;
    repeat (200) @(negedge clk);
    chk("R6 still locked inside wait limit", lock_flag[0], 1'b1);
    repeat (100) @(negedge clk);
    chk("R6 wait limit without partner drops lock", lock_flag[0], 1'b0);
  endtask

  task automatic t_powerdown;
    pd_pulse(0);
    pairs(0, 5, 1);
    @(negedge clk); pwr_dn[0] = 1'b1;
    #1;
    chk("R8 flag low in the power-down cycle", lock_flag[0], 1'b0);
    repeat (2) @(negedge clk); pwr_dn[0] = 1'b0;
    @(negedge clk);
    chk("R8 flag stays low after release", lock_flag[0], 1'b0);
    pairs(0, 4, 1);
    chk("R8 run count cleared by power-down", lock_flag[0], 1'b0);
    pair(0, 1'b0, 1);
    chk("R8 relock after five new good cycles", lock_flag[0], 1'b1);
  endtask

  task automatic t_independent;
    pd_pulse(0);
    pd_pulse(1);
    pairs(1, 5, 2);
    chk("R9 RF loop locks", lock_flag[1], 1'b1);
    chk("R9 IF loop unaffected by RF pulses", lock_flag[0], 1'b0);
    pairs(0, 5, 2);
    pd_pulse(1);
    chk("R9 IF lock survives RF power-down", lock_flag[0], 1'b1);
    chk("R9 RF lock cleared by its power-down", lock_flag[1], 1'b0);
  endtask

  task automatic t_mux;
    // Here IF is locked and RF is not.
    ana_lock = 1'b1; ref_div = 2'b01; fb_div = 2'b10;
    for (int s = 0; s < 8; s++) begin
      logic e;
      @(negedge clk);
      stat_sel = 3'(s);
      #1;
      case (s)
        0: e = ana_lock;
        1: e = 1'b1;
        2: e = 1'b0;
        3: e = 1'b0;
        4: e = ref_div[0];
        5: e = fb_div[0];
        6: e = ref_div[1];
        default: e = fb_div[1];
      endcase
      chk($sformatf("R10 select %0d", s), stat_out, e);
    end
    ana_lock = 1'b0; ref_div = 2'b10; fb_div = 2'b01;
    pairs(1, 5, 2);
    for (int s = 0; s < 8; s++) begin
      logic e;
      @(negedge clk);
      stat_sel = 3'(s);
      #1;
      case (s)
        0: e = 1'b0;
        1, 2, 3: e = 1'b1;
        4: e = 1'b0;
        5: e = 1'b1;
        6: e = 1'b1;
        default: e = 1'b0;
      endcase
      chk($sformatf("R10 select %0d both locked", s), stat_out, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; ref_pulse = '0; fb_pulse = '0; pwr_dn = '0;
    ana_lock = 1'b0; ref_div = '0; fb_div = '0; stat_sel = 3'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_entry_count();
    t_entry_bound();
    t_run_reset();
    t_hold_drop();
    t_missing();
    t_powerdown();
    t_independent();
    t_mux();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule